// File: doc/BRIEF.md
# Multi-Channel Monitor Alarm Checker

This block sits behind an analog-to-digital converter that measures five quantities one after another: the supply voltage, three external analog inputs and a temperature sensor. Each conversion arrives as a channel number with a 16-bit word. The block keeps the latest word per channel and marks that channel as freshly converted. It compares the word with two limits that software programs for that channel. A result outside the limits raises a sticky alarm flag.

The channels must arrive in a fixed rotation: supply, input 1, input 2, input 3, temperature, then supply again. The block tracks which channel it expects next. It drops any word tagged with another channel. Only the upper 12 bits of a word take part in the limit compare. The temperature word is compared as a signed value. The voltage words are compared as unsigned values.

Software reads and writes everything through a flat register port. Reads are combinational. Writes take effect at the clock edge. A per-channel enable lets either alarm of a channel raise the interrupt. A global enable gates a combined out-of-limit fault output.

Top module: `mon_alarm_top`

## Requirements
- R1: After reset, every result reads 0, the done, high-flag, low-flag and interrupt-enable registers read 0, the fault-enable bit is 0, and irq and fault are low.
- R2: Channel numbers are 0 = supply, 1 to 3 = external inputs, 4 = temperature, and the expected channel after reset is 0. An accepted word is readable at address 0 + channel, and done bit [channel] (address 24) is set at the same clock edge.
- R3: A word whose channel is not the expected one is dropped. No result, done bit or flag changes, and the expected channel stays the same.
- R4: Bits [3:0] of the word and of the limits are ignored in the compare.
- R5: For channels 0 to 3 the high flag (address 25, bit = channel) is set when the masked word is unsigned strictly greater than the masked high limit (address 8 + channel).
- R6: For channels 0 to 3 the low flag (address 26, bit = channel) is set when the masked word is unsigned strictly less than the masked low limit (address 16 + channel).
- R7: Channel 4 uses the same rules as R5 and R6, but the word and its limits are compared as two's-complement values.
- R8: Flags and done bits are sticky. They clear only when software writes 1 to their bit. A set and a clear in the same cycle leave the bit set.
- R9: irq is high while any flag is set whose channel bit is set in the interrupt enable (address 27).
- R10: fault is high while bit 0 of address 28 is 1 and any high or low flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_valid | input | 1 | A conversion word is present |
| conv_ch | input | 3 | Channel of the conversion word |
| conv_data | input | 16 | Left-justified conversion word |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| irq | output | 1 | Interrupt request |
| fault | output | 1 | Combined out-of-limit output |

## Verification
A wrong expected-channel pointer shows within one conversion. A word for the right channel is dropped, so its done bit stays clear on the next read. A wrong compare or sign choice shows as a wrong flag one edge after the word arrives. It also shows on irq or fault in that same cycle when they are enabled. A flag that loses its stickiness reads 0 after a later in-range word for that channel, one frame after the alarm.

// File: rtl/mon_pkg.sv
// Shared constants for the monitor alarm checker: register map offsets.
// Assumes a 5-bit register address and at most eight channels.
package mon_pkg;
    localparam int ADDR_W   = 5;
    localparam logic [ADDR_W-1:0] A_RES_BASE = 5'd0;
    localparam logic [ADDR_W-1:0] A_HI_BASE  = 5'd8;
    localparam logic [ADDR_W-1:0] A_LO_BASE  = 5'd16;
    localparam logic [ADDR_W-1:0] A_DONE     = 5'd24;
    localparam logic [ADDR_W-1:0] A_HIFLAG   = 5'd25;
    localparam logic [ADDR_W-1:0] A_LOFLAG   = 5'd26;
    localparam logic [ADDR_W-1:0] A_IRQEN    = 5'd27;
    localparam logic [ADDR_W-1:0] A_CTRL     = 5'd28;
endpackage

// File: rtl/mon_seq.sv
// Rotation tracker: holds the channel expected next and accepts a word
// only when its channel tag matches. Assumes channels 0..NUM_CH-1.
module mon_seq #(
    parameter int NUM_CH = 5,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            conv_valid,
    input  logic [CH_W-1:0] conv_ch,
    output logic [CH_W-1:0] exp_ch,
    output logic            accept
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    // Accept only the channel the rotation expects.
    always_comb accept = conv_valid && (conv_ch == exp_ch);

    // Advance the pointer after each accepted word, wrapping at the last channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            exp_ch <= '0;
        else if (accept)
            exp_ch <= (exp_ch == LAST_CH) ? '0 : exp_ch + 1'b1;
    end
endmodule

// File: rtl/mon_cmp.sv
// Limit comparator for one channel. Masks the low MASK_W bits of the word
// and both limits, then compares signed or unsigned depending on SIGNED_CMP.
module mon_cmp #(
    parameter int DATA_W     = 16,
    parameter int MASK_W     = 4,
    parameter bit SIGNED_CMP = 1'b0
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] hi_lim,
    input  logic [DATA_W-1:0] lo_lim,
    output logic              above,
    output logic              below
);
    localparam int SIG_W = DATA_W - MASK_W;

    logic [SIG_W-1:0] v_s, h_s, l_s;

    // Keep only the significant bits of each operand.
    always_comb begin
        v_s = value[DATA_W-1:MASK_W];
        h_s = hi_lim[DATA_W-1:MASK_W];
        l_s = lo_lim[DATA_W-1:MASK_W];
    end

    generate
        if (SIGNED_CMP) begin : g_signed
            // Two's-complement compare.
            always_comb begin
                above = $signed(v_s) > $signed(h_s);
                below = $signed(v_s) < $signed(l_s);
            end
        end else begin : g_unsigned
            // Unsigned compare.
            always_comb begin
                above = v_s > h_s;
                below = v_s < l_s;
            end
        end
    endgenerate
endmodule

// File: rtl/mon_alarm_top.sv
// Monitor alarm checker top. Stores per-channel results, done bits and
// sticky high/low alarm flags, and drives irq and fault. Assumes the
// converter delivers channels in rotation and that NUM_CH <= 8.
module mon_alarm_top
    import mon_pkg::*;
#(
    parameter int NUM_CH  = 5,
    parameter int DATA_W  = 16,
    parameter int MASK_W  = 4,
    parameter int TEMP_CH = 4,
    parameter int CH_W    = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [CH_W-1:0]   conv_ch,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              fault
);
    localparam logic [DATA_W-1:0] U_HI_RST = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] U_LO_RST = '0;
    localparam logic [DATA_W-1:0] S_HI_RST = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] S_LO_RST = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] result_q [NUM_CH];
    logic [DATA_W-1:0] hi_lim_q [NUM_CH];
    logic [DATA_W-1:0] lo_lim_q [NUM_CH];
    logic [NUM_CH-1:0] done_q, hi_flag_q, lo_flag_q, ien_q;
    logic              fault_en_q;

    logic [CH_W-1:0]   exp_ch;
    logic              accept;
    logic [NUM_CH-1:0] above_v, below_v, ch_hot;
    logic [NUM_CH-1:0] hi_set, lo_set, done_set;
    logic [NUM_CH-1:0] hi_clr, lo_clr, done_clr;
    logic [2:0]        idx;
    logic              idx_ok;

    mon_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid),
        .conv_ch(conv_ch), .exp_ch(exp_ch), .accept(accept)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            mon_cmp #(.DATA_W(DATA_W), .MASK_W(MASK_W),
                      .SIGNED_CMP(c == TEMP_CH)) u_cmp (
                .value(conv_data), .hi_lim(hi_lim_q[c]), .lo_lim(lo_lim_q[c]),
                .above(above_v[c]), .below(below_v[c])
            );

            // Per-channel limit registers, reset to values that never alarm.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hi_lim_q[c] <= (c == TEMP_CH) ? S_HI_RST : U_HI_RST;
                    lo_lim_q[c] <= (c == TEMP_CH) ? S_LO_RST : U_LO_RST;
                end else if (reg_wr) begin
                    if (reg_addr == A_HI_BASE + ADDR_W'(c)) hi_lim_q[c] <= reg_wdata;
                    if (reg_addr == A_LO_BASE + ADDR_W'(c)) lo_lim_q[c] <= reg_wdata;
                end
            end

            // Per-channel result register, loaded by an accepted word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    result_q[c] <= '0;
                else if (ch_hot[c])
                    result_q[c] <= conv_data;
            end
        end
    endgenerate

    // Decode the set and write-one-to-clear masks for this cycle.
    always_comb begin
        ch_hot   = accept ? (NUM_CH'(1) << conv_ch) : '0;
        done_set = ch_hot;
        hi_set   = ch_hot & above_v;
        lo_set   = ch_hot & below_v;
        done_clr = (reg_wr && reg_addr == A_DONE)   ? reg_wdata[NUM_CH-1:0] : '0;
        hi_clr   = (reg_wr && reg_addr == A_HIFLAG) ? reg_wdata[NUM_CH-1:0] : '0;
        lo_clr   = (reg_wr && reg_addr == A_LOFLAG) ? reg_wdata[NUM_CH-1:0] : '0;
    end

    // Sticky status bits: clear on write-one, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= '0;
            hi_flag_q <= '0;
            lo_flag_q <= '0;
        end else begin
            done_q    <= (done_q    & ~done_clr) | done_set;
            hi_flag_q <= (hi_flag_q & ~hi_clr)   | hi_set;
            lo_flag_q <= (lo_flag_q & ~lo_clr)   | lo_set;
        end
    end

    // Interrupt enables and global fault enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q      <= '0;
            fault_en_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_IRQEN) ien_q      <= reg_wdata[NUM_CH-1:0];
            if (reg_addr == A_CTRL)  fault_en_q <= reg_wdata[0];
        end
    end

    // Combined outputs from the sticky flags.
    always_comb begin
        irq   = |((hi_flag_q | lo_flag_q) & ien_q);
        fault = fault_en_q && |(hi_flag_q | lo_flag_q);
    end

    // Register read multiplexer.
    always_comb begin
        idx       = reg_addr[2:0];
        idx_ok    = 32'(idx) < NUM_CH;
        reg_rdata = '0;
        case (reg_addr[ADDR_W-1:3])
            2'd0: if (idx_ok) reg_rdata = result_q[idx];
            2'd1: if (idx_ok) reg_rdata = hi_lim_q[idx];
            2'd2: if (idx_ok) reg_rdata = lo_lim_q[idx];
            default: begin
                if (reg_addr == A_DONE)   reg_rdata = DATA_W'(done_q);
                if (reg_addr == A_HIFLAG) reg_rdata = DATA_W'(hi_flag_q);
                if (reg_addr == A_LOFLAG) reg_rdata = DATA_W'(lo_flag_q);
                if (reg_addr == A_IRQEN)  reg_rdata = DATA_W'(ien_q);
                if (reg_addr == A_CTRL)   reg_rdata = DATA_W'(fault_en_q);
            end
        endcase
    end
endmodule

// File: rtl/mon_alarm_chk.sv
// Assertion checker for mon_alarm_top, attached by bind. Observes the
// rotation pointer, sticky status bits and the fault output.
module mon_alarm_chk #(
    parameter int NUM_CH = 5,
    parameter int CH_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_valid,
    input logic [CH_W-1:0]   conv_ch,
    input logic              reg_wr,
    input logic [CH_W-1:0]   exp_ch,
    input logic [NUM_CH-1:0] done_q,
    input logic [NUM_CH-1:0] hi_flag_q,
    input logic [NUM_CH-1:0] lo_flag_q,
    input logic [NUM_CH-1:0] hi_clr,
    input logic [NUM_CH-1:0] lo_clr,
    input logic              fault_en_q,
    input logic              fault
);
    // Pointer never leaves the channel range (R2).
    assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(exp_ch) < NUM_CH);

    // Accepted word sets its done bit at the next edge (R2).
    assert_done_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && conv_ch == exp_ch) |=> done_q[$past(exp_ch)]);

    // Out-of-rotation word changes no status (R3).
    assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && conv_ch != exp_ch && !reg_wr) |=>
        ($stable(done_q) && $stable(hi_flag_q) && $stable(lo_flag_q) && $stable(exp_ch)));

    // A set high flag survives unless cleared (R8).
    assert_hi_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hi_flag_q) & ~$past(hi_clr) & ~hi_flag_q) == '0));

    // A set low flag survives unless cleared (R8).
    assert_lo_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(lo_flag_q) & ~$past(lo_clr) & ~lo_flag_q) == '0));

    // Fault stays low while disabled (R10).
    assert_fault_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_en_q |-> !fault);
endmodule

bind mon_alarm_top mon_alarm_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ch(conv_ch),
    .reg_wr(reg_wr), .exp_ch(exp_ch), .done_q(done_q), .hi_flag_q(hi_flag_q),
    .lo_flag_q(lo_flag_q), .hi_clr(hi_clr), .lo_clr(lo_clr),
    .fault_en_q(fault_en_q), .fault(fault)
);

// File: tb/test_mon_alarm_top.sv
module test_mon_alarm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [2:0]  conv_ch = '0;
    logic [15:0] conv_data = '0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, fault;

    int total = 0;
    int bad   = 0;
    logic [15:0] rv;

    always #2.5 clk = ~clk;

    mon_alarm_top i_mon_alarm_top (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ch(conv_ch),
        .conv_data(conv_data), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .fault(fault)
    );

    // {channel, word, expect high flag, expect low flag}
    localparam int NV = 15;
    localparam logic [20:0] VEC [NV] = '{
        {3'd0, 16'h800F, 1'b0, 1'b0},  // R4 low bits ignored
        {3'd1, 16'h4010, 1'b1, 1'b0},  // R5
        {3'd2, 16'h0FFF, 1'b0, 1'b1},  // R6, R4
        {3'd3, 16'h1000, 1'b0, 1'b0},  // R6 equal is in range
        {3'd4, 16'h2810, 1'b1, 1'b0},  // R7 positive above
        {3'd0, 16'h1FF0, 1'b0, 1'b1},  // R6
        {3'd1, 16'h0000, 1'b0, 1'b1},  // R6
        {3'd2, 16'hFFFF, 1'b1, 1'b0},  // R5
        {3'd3, 16'h400F, 1'b0, 1'b0},  // R4
        {3'd4, 16'hF000, 1'b0, 1'b1},  // R7 negative below
        {3'd0, 16'h5000, 1'b0, 1'b0},  // R5 R6 in range
        {3'd1, 16'h2000, 1'b0, 1'b0},
        {3'd2, 16'h3000, 1'b0, 1'b0},
        {3'd3, 16'h0800, 1'b0, 1'b1},
        {3'd4, 16'h0000, 1'b0, 1'b0}   // R7 zero above negative low limit
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cv(input logic [2:0] c, input logic [15:0] d);
        @(negedge clk);
        conv_valid = 1'b1; conv_ch = c; conv_data = d;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    task automatic clr_all();
        wr(5'd24, 16'h001F);
        wr(5'd25, 16'h001F);
        wr(5'd26, 16'h001F);
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'd0, rv);  chk("R1 result0", rv, 16'h0000);
        rd(5'd4, rv);  chk("R1 result4", rv, 16'h0000);
        rd(5'd24, rv); chk("R1 done", rv, 16'h0000);
        rd(5'd25, rv); chk("R1 hiflag", rv, 16'h0000);
        rd(5'd26, rv); chk("R1 loflag", rv, 16'h0000);
        rd(5'd27, rv); chk("R1 irqen", rv, 16'h0000);
        rd(5'd28, rv); chk("R1 ctrl", rv, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 fault", {15'd0, fault}, 16'd0);

        // Program limits
        wr(5'd8, 16'h8000);  wr(5'd16, 16'h2000);
        for (int c = 1; c < 4; c++) begin
            wr(5'(8 + c), 16'h4000);
            wr(5'(16 + c), 16'h1000);
        end
        wr(5'd12, 16'h2800); wr(5'd20, 16'hF600);

        // Table walk: R2, R4-R7
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  c;
            logic [15:0] d;
            c = VEC[i][20:18];
            d = VEC[i][17:2];
            cv(c, d);
            rd(5'(c), rv);  chk("R2 result", rv, d);
            rd(5'd24, rv);  chk("R2 done", rv, 16'(1) << c);
            rd(5'd25, rv);  chk("R5 R7 hiflag", rv, VEC[i][1] ? (16'(1) << c) : 16'h0);
            rd(5'd26, rv);  chk("R6 R7 loflag", rv, VEC[i][0] ? (16'(1) << c) : 16'h0);
            clr_all();
        end

        // R3: expected channel is 0, offer channel 2
        cv(3'd2, 16'hFFFF);
        rd(5'd2, rv);  chk("R3 result kept", rv, 16'h3000);
        rd(5'd24, rv); chk("R3 done kept", rv, 16'h0000);
        rd(5'd25, rv); chk("R3 hiflag kept", rv, 16'h0000);
        cv(3'd0, 16'h3000);
        rd(5'd24, rv); chk("R3 pointer kept", rv, 16'h0001);
        clr_all();

        // R8 sticky, R9 irq, R10 fault
        wr(5'd27, 16'h0002);
        cv(3'd1, 16'h5000);
        chk("R9 irq on", {15'd0, irq}, 16'd1);
        chk("R10 fault gated", {15'd0, fault}, 16'd0);
        wr(5'd28, 16'h0001);
        chk("R10 fault on", {15'd0, fault}, 16'd1);
        cv(3'd2, 16'h2000); cv(3'd3, 16'h2000); cv(3'd4, 16'h0000); cv(3'd0, 16'h3000);
        cv(3'd1, 16'h2000);
        rd(5'd25, rv); chk("R8 hi sticky", rv, 16'h0002);
        wr(5'd27, 16'h0001);
        chk("R9 irq masked", {15'd0, irq}, 16'd0);
        wr(5'd25, 16'h0001);
        rd(5'd25, rv); chk("R8 other bit kept", rv, 16'h0002);
        wr(5'd25, 16'h0002);
        rd(5'd25, rv); chk("R8 cleared", rv, 16'h0000);
        chk("R10 fault off", {15'd0, fault}, 16'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule